// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of an 8-bit successive-approximation converter with four analog inputs. A conversion starts in one of two ways. Software can pulse a start strobe, or, when the external-start enable is set, a falling edge on an external trigger pin can start one. The block presents a channel number and a trial code to the analog part outside it, which holds the multiplexer, the ladder and the comparator. The block reads back a single comparator bit, which is 1 when the selected input is at or above the trial level. It resolves the result from the most significant bit down.

All timing counts machine cycles, which a one-clock tick input marks. A conversion lasts 24 or 48 ticks, chosen by a length-select input. The first 6 ticks are a sampling window. The eight bit decisions are spaced evenly after that window, and a two-tick tail ends the conversion.

The block keeps a busy flag and a done flag, and the done flag doubles as the interrupt request. A start that arrives while either flag is set is dropped. The channel select is locked while either flag is set. A power-down input aborts a running conversion but keeps a finished result.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `chan` values 0, 1, 2 and 3 select inputs 0 to 3. A finished conversion leaves in `result` the largest code whose trial the comparator accepts, so `result` equals the selected input's level.
- R2: With `long_conv` = 0 at acceptance, busy stays high for 24 ticks counted from the accepting clock edge. With `long_conv` = 1 it stays high for 48 ticks.
- R3: A one-clock `sw_start` pulse sets busy on the next clock edge when busy, done and `pdown` are all 0. Busy then stays high until the conversion ends, and no input can clear it except `pdown`.
- R4: With `ext_en` = 1, a falling edge on `ext_start_n` starts a conversion. The pin is sampled only on ticks, and the start takes effect one clock after the second tick that sees the low level. With `ext_en` = 0 the pin has no effect.
- R5: A start request from either source is discarded while busy or done is 1, and it does not disturb a running conversion.
- R6: `done_irq` rises on the tick that ends the second-to-last machine cycle of a conversion, while busy is still 1. Busy falls on the next tick, so both flags are 1 for exactly one machine cycle.
- R7: Only a `sw_done_clr` pulse clears `done_irq`. A completion on the same edge takes priority over the clear. `result` keeps its value while `done_irq` is 1.
- R8: A `sel_we` write loads `sel_in` into `chan` only when busy and done are both 0. At any other time the write is ignored.
- R9: `pdown` = 1 clears busy on the next clock edge and blocks new starts while it is high. It leaves `done_irq` and `result` unchanged.
- R10: Each conversion begins with trial code 0x80. The eight trial bits are then resolved MSB first, one per step, and every bit is resolved before completion.
- R11: After a synchronous reset, busy, `done_irq`, `result`, `chan` and `dac_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_tick | input | 1 | One-clock pulse per machine cycle |
| sw_start | input | 1 | Software start strobe |
| sw_done_clr | input | 1 | Software clear strobe for the done flag |
| sel_we | input | 1 | Channel-select write strobe |
| sel_in | input | 2 | Channel value to write |
| long_conv | input | 1 | 0 selects the 24-tick conversion, 1 selects the 48-tick conversion |
| ext_en | input | 1 | Enables the external trigger pin |
| ext_start_n | input | 1 | External trigger pin, acts on a falling edge |
| pdown | input | 1 | Power-down entry, aborts a running conversion |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| busy | output | 1 | Conversion in progress |
| done_irq | output | 1 | Conversion complete, also the interrupt request |
| result | output | 8 | Last finished conversion result |
| chan | output | 2 | Selected channel |
| dac_code | output | 8 | Trial code sent to the ladder |

## Verification
The assertions check on every cycle the flag rules that hold whatever the stimulus. Done may only rise while busy is still high, and the overlap of the two flags ends on the next tick. Busy may only rise after a cycle in which done was clear. The channel and the stored result stay frozen while the flags lock them. Power-down drops busy, and trigger pulses line up with ticks. Every conversion also opens with code 0x80 and has resolved all eight bits by the time it completes. Only the bench's scenarios can show the things that depend on the analog input and on time: the exact 24- and 48-tick lengths, that the result equals each channel's level, which start requests are lost, and that a kept result survives power-down. The bench's reference model compares all four state outputs with its own expected values on every clock.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Ticks given to each bit decision once the sampling window is over.
  function automatic int step_ticks(input int total, input int sample, input int bits);
    return (total - sample) / bits;
  endfunction

  // Ticks left after the last decision, before busy drops.
  function automatic int tail_ticks(input int total, input int sample, input int bits);
    return total - sample - bits * step_ticks(total, sample, bits);
  endfunction

endpackage

// File: rtl/adc_ext_trig.sv
module adc_ext_trig (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin_n,
  output logic fall
);

  logic s1_q, s2_q, fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      fall_q <= 1'b0;
    end else begin
      fall_q <= tick & s2_q & ~s1_q;
      if (tick) begin
        s1_q <= pin_n;
        s2_q <= s1_q;
      end
    end
  end

  assign fall = fall_q;

  AST_EXT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    fall_q |-> $past(tick)); // R4

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES        = 8,
  parameter int SAMPLE_CYC = 6,
  parameter int SHORT_CYC  = 24,
  parameter int LONG_CYC   = 48
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           go,
  input  logic           abort,
  input  logic           long_sel,
  input  logic           cmp,
  output logic           running,
  output logic           fin,
  output logic [RES-1:0] code
);

  localparam int CNT_W  = $clog2(LONG_CYC + 1);
  localparam int STEP_S = adc_seq_pkg::step_ticks(SHORT_CYC, SAMPLE_CYC, RES);
  localparam int STEP_L = adc_seq_pkg::step_ticks(LONG_CYC, SAMPLE_CYC, RES);
  localparam int STEP_W = $clog2(STEP_L + 1);
  localparam logic [RES-1:0] MSB = {1'b1, {(RES-1){1'b0}}};

  logic             run_q, long_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RES-1:0]   sar_q, mask_q;
  logic [STEP_W-1:0] step_q;

  logic [CNT_W-1:0]  last_c, pen_c;
  logic [STEP_W-1:0] reload_c;
  logic              in_steps, decide;

  generate
    if (adc_seq_pkg::tail_ticks(SHORT_CYC, SAMPLE_CYC, RES) < 2 ||
        adc_seq_pkg::tail_ticks(LONG_CYC, SAMPLE_CYC, RES) < 2) begin : g_bad_len
      initial $error("conversion lengths leave no room for the completion tail");
    end
  endgenerate

  assign last_c   = long_q ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
  assign pen_c    = long_q ? CNT_W'(LONG_CYC - 2) : CNT_W'(SHORT_CYC - 2);
  assign reload_c = long_q ? STEP_W'(STEP_L - 1)  : STEP_W'(STEP_S - 1);
  assign in_steps = cnt_q >= CNT_W'(SAMPLE_CYC);
  assign decide   = run_q && tick && in_steps && (mask_q != '0) && (step_q == '0);
  assign fin      = run_q && tick && !abort && (cnt_q == pen_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      long_q <= 1'b0;
      cnt_q  <= '0;
      sar_q  <= '0;
      mask_q <= '0;
      step_q <= '0;
    end else if (abort) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (go) begin
      run_q  <= 1'b1;
      long_q <= long_sel;
      cnt_q  <= '0;
      sar_q  <= MSB;
      mask_q <= MSB;
      step_q <= long_sel ? STEP_W'(STEP_L - 1) : STEP_W'(STEP_S - 1);
    end else if (run_q && tick) begin
      if (cnt_q == last_c) begin
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (in_steps && mask_q != '0) begin
        if (step_q == '0) begin
          step_q <= reload_c;
        end else begin
          step_q <= step_q - 1'b1;
        end
      end
      if (decide) begin
        sar_q  <= (cmp ? sar_q : (sar_q & ~mask_q)) | (mask_q >> 1);
        mask_q <= mask_q >> 1;
      end
    end
  end

  assign running = run_q;
  assign code    = sar_q;

  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> (sar_q == MSB && mask_q == MSB)); // R10
  AST_ALL_BITS: assert property (@(posedge clk) disable iff (rst)
    fin |-> (mask_q == '0)); // R10
  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_q && !$rose(run_q) && !abort && !go) |-> $countones(mask_q) <= 1); // R10

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES        = 8,
  parameter int CH_W       = 2,
  parameter int SAMPLE_CYC = 6,
  parameter int SHORT_CYC  = 24,
  parameter int LONG_CYC   = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mc_tick,
  input  logic            sw_start,
  input  logic            sw_done_clr,
  input  logic            sel_we,
  input  logic [CH_W-1:0] sel_in,
  input  logic            long_conv,
  input  logic            ext_en,
  input  logic            ext_start_n,
  input  logic            pdown,
  input  logic            cmp_in,
  output logic            busy,
  output logic            done_irq,
  output logic [RES-1:0]  result,
  output logic [CH_W-1:0] chan,
  output logic [RES-1:0]  dac_code
);

  logic            ext_fall, run, fin, go, req;
  logic            done_q;
  logic [RES-1:0]  result_q, code;
  logic [CH_W-1:0] chan_q;

  adc_ext_trig u_trig (
    .clk   (clk),
    .rst   (rst),
    .tick  (mc_tick),
    .pin_n (ext_start_n),
    .fall  (ext_fall)
  );

  assign req = sw_start | (ext_en & ext_fall);
  assign go  = req & ~run & ~done_q & ~pdown;

  adc_sar_core #(
    .RES        (RES),
    .SAMPLE_CYC (SAMPLE_CYC),
    .SHORT_CYC  (SHORT_CYC),
    .LONG_CYC   (LONG_CYC)
  ) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (mc_tick),
    .go       (go),
    .abort    (pdown),
    .long_sel (long_conv),
    .cmp      (cmp_in),
    .running  (run),
    .fin      (fin),
    .code     (code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      result_q <= '0;
      chan_q   <= '0;
    end else begin
      if (fin) begin
        done_q   <= 1'b1;
        result_q <= code;
      end else if (sw_done_clr) begin
        done_q <= 1'b0;
      end
      if (sel_we && !run && !done_q) begin
        chan_q <= sel_in;
      end
    end
  end

  assign busy     = run;
  assign done_irq = done_q;
  assign result   = result_q;
  assign chan     = chan_q;
  assign dac_code = code;

  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> run); // R6
  AST_OVERLAP_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
    (run && done_q && mc_tick) |=> !run); // R6
  AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> !$past(done_q)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done_q && $past(done_q)) |-> $stable(result_q)); // R7
  AST_CHAN_LOCK: assert property (@(posedge clk) disable iff (rst)
    (run || done_q) |=> $stable(chan_q)); // R8
  AST_PDOWN_ABORT: assert property (@(posedge clk) disable iff (rst)
    pdown |=> !run); // R9
  AST_PDOWN_KEEP: assert property (@(posedge clk) disable iff (rst)
    (pdown && done_q && !sw_done_clr) |=> done_q); // R9

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       mc_tick = 1'b0;
  logic       sw_start = 1'b0, sw_done_clr = 1'b0, sel_we = 1'b0;
  logic [1:0] sel_in = 2'd0;
  logic       long_conv = 1'b0, ext_en = 1'b0, ext_start_n = 1'b1, pdown = 1'b0;
  logic       cmp_in;
  logic       busy, done_irq;
  logic [7:0] result, dac_code;
  logic [1:0] chan;
  logic [7:0] vin [4];

  assign cmp_in = (vin[chan] >= dac_code);

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst(rst), .mc_tick(mc_tick), .sw_start(sw_start),
    .sw_done_clr(sw_done_clr), .sel_we(sel_we), .sel_in(sel_in),
    .long_conv(long_conv), .ext_en(ext_en), .ext_start_n(ext_start_n),
    .pdown(pdown), .cmp_in(cmp_in), .busy(busy), .done_irq(done_irq),
    .result(result), .chan(chan), .dac_code(dac_code)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tdiv = 0;
  int tick_total = 0;

  // machine-cycle tick: one clock in four
  always @(negedge clk) begin
    tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
    mc_tick <= (tdiv == 3);
  end
  always @(posedge clk) if (mc_tick) tick_total <= tick_total + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_busy, m_done, m_res, m_chan, m_cchan, m_len, m_n;
  int m_p1, m_p2, m_fall, m_live;

  always @(posedge clk) begin
    int ob, od, req, setd, nf;
    if (rst) begin
      m_busy = 0; m_done = 0; m_res = 0; m_chan = 0; m_cchan = 0;
      m_len = 24; m_n = 0; m_p1 = 1; m_p2 = 1; m_fall = 0; m_live = 0;
    end else begin
      m_live = 1;
      ob = m_busy; od = m_done; setd = 0;
      req = sw_start || (ext_en && m_fall);
      if (sel_we && !ob && !od) m_chan = sel_in;
      if (pdown) begin
        m_busy = 0;
      end else if (req && !ob && !od) begin
        m_busy = 1; m_n = 0; m_len = long_conv ? 48 : 24; m_cchan = m_chan;
      end else if (ob && mc_tick) begin
        m_n++;
        if (m_n == m_len - 1) begin
          m_done = 1; setd = 1; m_res = vin[m_cchan];
        end
        if (m_n == m_len) m_busy = 0;
      end
      if (sw_done_clr && !setd) m_done = 0;
      nf = (mc_tick && m_p2 == 1 && m_p1 == 0) ? 1 : 0;
      if (mc_tick) begin m_p2 = m_p1; m_p1 = int'(ext_start_n); end
      m_fall = nf;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (m_live == 1) begin
      chk("R3/R9 busy per-cycle", int'(busy), m_busy);
      chk("R6/R7 done per-cycle", int'(done_irq), m_done);
      chk("R1/R7 result per-cycle", int'(result), m_res);
      chk("R8 chan per-cycle", int'(chan), m_chan);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic wait_flag(input bit want_done, input bit level);
    int g = 0;
    while (((want_done ? done_irq : busy) != level) && g < 4000) begin
      @(negedge clk); g++;
    end
  endtask

  task automatic clear_done();
    @(negedge clk); sw_done_clr = 1'b1;
    @(negedge clk); sw_done_clr = 1'b0;
    chk("R7 done cleared by strobe", int'(done_irq), 0);
  endtask

  task automatic run_conv(input int ch, input bit lng);
    int t0, len;
    len = lng ? 48 : 24;
    @(negedge clk); sel_we = 1'b1; sel_in = 2'(ch); long_conv = lng; sw_start = 1'b1;
    @(negedge clk); sel_we = 1'b0; sw_start = 1'b0;
    chk("R3 busy after start", int'(busy), 1);
    chk("R10 first trial code", int'(dac_code), 8'h80);
    t0 = tick_total;
    wait_flag(1'b1, 1'b1);
    chk("R6 done tick position", tick_total - t0, len - 1);
    chk("R6 busy still high at done", int'(busy), 1);
    wait_flag(1'b0, 1'b0);
    chk("R2 conversion length", tick_total - t0, len);
    chk("R1 result equals input level", int'(result), int'(vin[ch]));
    chk("R1 channel used", int'(chan), ch);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    vin[0] = 8'hA5; vin[1] = 8'h00; vin[2] = 8'hFF; vin[3] = 8'h3C;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset done", int'(done_irq), 0);
    chk("R11 reset result", int'(result), 0);
    chk("R11 reset chan", int'(chan), 0);
    chk("R11 reset code", int'(dac_code), 0);

    // R1 R2: every channel, both lengths
    run_conv(0, 1'b0); clear_done();
    run_conv(1, 1'b1); clear_done();
    run_conv(2, 1'b0); clear_done();
    run_conv(3, 1'b1); clear_done();
    vin[0] = 8'h01;
    run_conv(0, 1'b0);

    // R5 R7 R8: start and channel write while done is set
    @(negedge clk); sw_start = 1'b1; sel_we = 1'b1; sel_in = 2'd2;
    @(negedge clk); sw_start = 1'b0; sel_we = 1'b0;
    wait_ticks(3);
    chk("R5 start dropped while done", int'(busy), 0);
    chk("R8 chan write ignored while done", int'(chan), 0);
    chk("R7 result held while done", int'(result), 8'h01);
    clear_done();

    // R5 R8: start and channel write while busy
    @(negedge clk); sel_we = 1'b1; sel_in = 2'd3; long_conv = 1'b0; sw_start = 1'b1;
    @(negedge clk); sel_we = 1'b0; sw_start = 1'b0;
    begin
      int t0;
      t0 = tick_total;
      wait_ticks(10);
      @(negedge clk); sw_start = 1'b1; sel_we = 1'b1; sel_in = 2'd1; long_conv = 1'b1;
      @(negedge clk); sw_start = 1'b0; sel_we = 1'b0;
      chk("R8 chan write ignored while busy", int'(chan), 3);
      wait_flag(1'b0, 1'b0);
      chk("R5 busy start did not restart", tick_total - t0, 24);
      chk("R5 result after ignored start", int'(result), int'(vin[3]));
    end
    clear_done();
    long_conv = 1'b0;

    // R4: external trigger enabled
    @(negedge clk); ext_en = 1'b1; sel_we = 1'b1; sel_in = 2'd2;
    @(negedge clk); sel_we = 1'b0; ext_start_n = 1'b0;
    wait_flag(1'b0, 1'b1);
    chk("R4 external edge starts", int'(busy), 1);
    ext_start_n = 1'b1;
    wait_flag(1'b1, 1'b1);
    wait_flag(1'b0, 1'b0);
    chk("R4 external conversion result", int'(result), 8'hFF);
    clear_done();

    // R4: external trigger disabled
    @(negedge clk); ext_en = 1'b0; ext_start_n = 1'b0;
    wait_ticks(5);
    ext_start_n = 1'b1;
    wait_ticks(5);
    chk("R4 pin ignored when disabled", int'(busy), 0);
    chk("R4 no done when disabled", int'(done_irq), 0);

    // R9: abort, block while held, keep a finished result
    @(negedge clk); sel_we = 1'b1; sel_in = 2'd0; sw_start = 1'b1; long_conv = 1'b1;
    @(negedge clk); sel_we = 1'b0; sw_start = 1'b0;
    wait_ticks(10);
    @(negedge clk); pdown = 1'b1;
    @(negedge clk);
    chk("R9 abort clears busy", int'(busy), 0);
    sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
    @(negedge clk);
    chk("R9 start blocked in power-down", int'(busy), 0);
    chk("R9 abort leaves done clear", int'(done_irq), 0);
    pdown = 1'b0;
    wait_ticks(60);
    chk("R9 aborted run never completes", int'(done_irq), 0);
    vin[1] = 8'h5A;
    run_conv(1, 1'b0);
    @(negedge clk); pdown = 1'b1;
    repeat (3) @(negedge clk);
    pdown = 1'b0;
    @(negedge clk);
    chk("R9 done kept across power-down", int'(done_irq), 1);
    chk("R9 result kept across power-down", int'(result), 8'h5A);
    clear_done();
    wait_ticks(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule